// File: doc/BRIEF.md
# Debug Entry Status Recorder

This block keeps a record of why a processor core last stopped for debug and where the core is in its halt and resume sequence. Six event lines come in from the debug logic. Each one stands for a different kind of stop: a halt command from the debug port, a hardware breakpoint, a data watchpoint, a software breakpoint instruction, an external debug request line and a vector catch. The block stores a 4-bit cause code for the event that wins. It also keeps a halted flag and a restarted flag that follow the core's own state lines.

On a watchpoint, the block also stores a fault address. This is the address of the instruction that caused the watchpoint, plus an offset that depends on the instruction-set state the core was fetching in. The core can read and write the status word and the fault address through a single-cycle register port. The external debugger sees the status bits on a read-only output. Events that arrive while the core is already halted do not change the cause code, so a debugger that inspects a stopped core always sees the original reason for the stop.

Top module: `dbg_entry_recorder`

## Requirements
- R1: After reset the cause code is 0000, the restarted flag is 1, the halted flag is 0 and the fault address is 0.
- R2: When the core is not halted and a single event line is high, the cause code becomes, one clock later, 0000 for a halt command, 0001 for a breakpoint, 0010 for a watchpoint, 0011 for a software breakpoint, 0100 for an external request or 0101 for a vector catch.
- R3: When several event lines are high in the same cycle, the event with the numerically lowest code is recorded.
- R4: While `coreHalted` is 1, event lines do not change the cause code.
- R5: The halted flag equals `coreHalted` delayed by one clock.
- R6: The restarted flag equals the inverse of `coreRestarting` delayed by one clock.
- R7: When the watchpoint is the recorded cause, the fault address becomes `wpAddr` plus an offset set by `wpState`: 8 for state 00 (32-bit instructions), 4 for state 01 (16-bit instructions), and 0 for states 10 and 11 (bytecode).
- R8: `abortEvt` (a precise abort) changes neither the fault address nor the cause code.
- R9: A core write with `regSel` = 0 loads bits [5:2] of the write data into the cause code. This works even while halted. Bits [1:0] of the write are ignored. A recorded event in the same cycle takes precedence over the write.
- R10: A core write with `regSel` = 1 loads the full write data into the fault address. A watchpoint capture in the same cycle takes precedence over the write.
- R11: `regRdData` returns {26'b0, cause, restarted, halted} for `regSel` = 0, the fault address for `regSel` = 1, and zero for `regSel` 2 or 3. `statusOut` always shows {cause, restarted, halted}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtHaltReq | input | 1 | Halt command from the debug port |
| evtBreak | input | 1 | Hardware breakpoint hit |
| evtWatch | input | 1 | Data watchpoint hit |
| evtSwBkpt | input | 1 | Software breakpoint instruction |
| evtExtReq | input | 1 | External debug request line |
| evtVecCatch | input | 1 | Vector catch hit |
| abortEvt | input | 1 | Precise prefetch or data abort, for observation only |
| coreHalted | input | 1 | Core is in debug state |
| coreRestarting | input | 1 | Core is leaving debug state |
| wpState | input | 2 | Instruction-set state of the watchpoint instruction |
| wpAddr | input | 32 | Address of the watchpoint instruction |
| regWrEn | input | 1 | Core register write strobe |
| regSel | input | 2 | Register select: 0 status, 1 fault address |
| regWrData | input | 32 | Core write data |
| regRdData | output | 32 | Core read data for the selected register |
| statusOut | output | 6 | External read-only view {cause, restarted, halted} |

## Verification
The hardest cases to reach are collisions in a single cycle. One is a watchpoint that loses priority to a halt command or a breakpoint while a software write to the fault address is also pending. Another is an event that arrives while the core is halted at the same moment as a write to the status word. Random stimulus drives each event line with a quarter probability and holds the core halted about a third of the time, so these overlaps occur often. Directed steps also force each one explicitly, including every `wpState` value.

// File: rtl/dbg_rec_pkg.sv
package dbg_rec_pkg;
  localparam int NUM_EVT = 6;
  localparam int CAUSE_W = 4;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_STATUS = 2'd0;
  localparam logic [SEL_W-1:0] SEL_FAULT = 2'd1;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_HALT   = 4'd0,
    CAUSE_BREAK  = 4'd1,
    CAUSE_WATCH  = 4'd2,
    CAUSE_SWBKPT = 4'd3,
    CAUSE_EXTREQ = 4'd4,
    CAUSE_VCATCH = 4'd5
  } causeE;

  typedef struct packed {
    logic                causeLd;
    logic [CAUSE_W-1:0]  causeVal;
    logic                faultCap;
    logic                faultWr;
  } strobeT;
endpackage

// File: rtl/dbg_rec_ctrl.sv
module dbg_rec_ctrl
  import dbg_rec_pkg::*;
(
  input  logic [NUM_EVT-1:0] evtVec,
  input  logic               coreHalted,
  input  logic               regWrEn,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [CAUSE_W-1:0] wrCause,
  output strobeT             strobe
);
  logic [CAUSE_W-1:0] pick;
  logic anyEvt;
  logic recordEvt;

  // lowest index wins: scan from top down so the last hit is the lowest
  always_comb begin
    pick = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (evtVec[i]) pick = CAUSE_W'(i);
    end
  end

  assign anyEvt = |evtVec;
  assign recordEvt = anyEvt && !coreHalted;

  always_comb begin
    strobe = '0;
    if (recordEvt) begin
      strobe.causeLd = 1'b1;
      strobe.causeVal = pick;
    end else if (regWrEn && regSel == SEL_STATUS) begin
      strobe.causeLd = 1'b1;
      strobe.causeVal = wrCause;
    end
    strobe.faultCap = recordEvt && (pick == CAUSE_WATCH);
    strobe.faultWr = regWrEn && (regSel == SEL_FAULT) && !strobe.faultCap;
  end
endmodule

// File: rtl/dbg_rec_dpath.sv
module dbg_rec_dpath
  import dbg_rec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic               coreHalted,
  input  logic               coreRestarting,
  input  logic [1:0]         wpState,
  input  logic [ADDR_W-1:0]  wpAddr,
  input  logic [ADDR_W-1:0]  regWrData,
  input  logic [SEL_W-1:0]   regSel,
  output logic [ADDR_W-1:0]  regRdData,
  output logic [CAUSE_W+1:0] statusWord,
  output logic [ADDR_W-1:0]  faultQ
);
  localparam int STAT_W = CAUSE_W + 2;

  logic [CAUSE_W-1:0] causeQ;
  logic haltedQ;
  logic restartedQ;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    unique case (wpState)
      2'b00:   offset = ADDR_W'(8);
      2'b01:   offset = ADDR_W'(4);
      default: offset = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= '0;
      haltedQ <= 1'b0;
      restartedQ <= 1'b1;
      faultQ <= '0;
    end else begin
      haltedQ <= coreHalted;
      restartedQ <= !coreRestarting;
      if (strobe.causeLd) causeQ <= strobe.causeVal;
      if (strobe.faultCap) faultQ <= wpAddr + offset;
      else if (strobe.faultWr) faultQ <= regWrData;
    end
  end

  assign statusWord = {causeQ, restartedQ, haltedQ};

  always_comb begin
    case (regSel)
      SEL_STATUS: regRdData = {{(ADDR_W-STAT_W){1'b0}}, statusWord};
      SEL_FAULT:  regRdData = faultQ;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dbg_entry_recorder.sv
module dbg_entry_recorder
  import dbg_rec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtHaltReq,
  input  logic              evtBreak,
  input  logic              evtWatch,
  input  logic              evtSwBkpt,
  input  logic              evtExtReq,
  input  logic              evtVecCatch,
  input  logic              abortEvt,
  input  logic              coreHalted,
  input  logic              coreRestarting,
  input  logic [1:0]        wpState,
  input  logic [ADDR_W-1:0] wpAddr,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output logic [5:0]        statusOut
);
  strobeT strobe;
  logic [NUM_EVT-1:0] evtVec;
  logic [ADDR_W-1:0] faultQ;
  logic abortSeen;

  // precise aborts are observed but deliberately leave all state alone
  assign abortSeen = abortEvt;

  assign evtVec = {evtVecCatch, evtExtReq, evtSwBkpt, evtWatch, evtBreak, evtHaltReq};

  dbg_rec_ctrl u_ctrl (
    .evtVec(evtVec),
    .coreHalted(coreHalted),
    .regWrEn(regWrEn),
    .regSel(regSel),
    .wrCause(regWrData[5:2]),
    .strobe(strobe)
  );

  dbg_rec_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .coreHalted(coreHalted),
    .coreRestarting(coreRestarting),
    .wpState(wpState),
    .wpAddr(wpAddr),
    .regWrData(regWrData),
    .regSel(regSel),
    .regRdData(regRdData),
    .statusWord(statusOut),
    .faultQ(faultQ)
  );
endmodule

// File: rtl/dbg_entry_recorder_chk.sv
module dbg_entry_recorder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              evtHaltReq,
  input logic              evtBreak,
  input logic              evtWatch,
  input logic              coreHalted,
  input logic              coreRestarting,
  input logic [1:0]        wpState,
  input logic [ADDR_W-1:0] wpAddr,
  input logic              regWrEn,
  input logic [1:0]        regSel,
  input logic [5:0]        statusOut,
  input logic [ADDR_W-1:0] faultQ
);
  // R5
  halted_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusOut[0] == $past(coreHalted));

  // R6
  restarted_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusOut[1] == !$past(coreRestarting));

  // R4
  cause_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreHalted && !(regWrEn && regSel == 2'd0)) |=> $stable(statusOut[5:2]));

  // R3
  halt_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtHaltReq && !coreHalted) |=> statusOut[5:2] == 4'd0);

  // R7
  wp_wide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtWatch && !evtHaltReq && !evtBreak && !coreHalted && wpState == 2'b00)
      |=> faultQ == $past(wpAddr) + ADDR_W'(8));

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(evtWatch && !coreHalted) && !(regWrEn && regSel == 2'd1)) |=> $stable(faultQ));
endmodule

bind dbg_entry_recorder dbg_entry_recorder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .evtHaltReq(evtHaltReq),
  .evtBreak(evtBreak),
  .evtWatch(evtWatch),
  .coreHalted(coreHalted),
  .coreRestarting(coreRestarting),
  .wpState(wpState),
  .wpAddr(wpAddr),
  .regWrEn(regWrEn),
  .regSel(regSel),
  .statusOut(statusOut),
  .faultQ(faultQ)
);

// File: tb/dbg_entry_recorder_bench.sv
module dbg_entry_recorder_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] ev = '0;
  logic abortEvt = 1'b0;
  logic coreHalted = 1'b0;
  logic coreRestarting = 1'b0;
  logic [1:0] wpState = '0;
  logic [31:0] wpAddr = '0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [5:0] statusOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [3:0] expCause = 4'd0;
  logic expRest = 1'b1;
  logic expHalt = 1'b0;
  logic [31:0] expFault = '0;

  always #5 clk = ~clk;

  dbg_entry_recorder u_dbg_entry_recorder (
    .clk(clk), .rstN(rstN),
    .evtHaltReq(ev[0]), .evtBreak(ev[1]), .evtWatch(ev[2]),
    .evtSwBkpt(ev[3]), .evtExtReq(ev[4]), .evtVecCatch(ev[5]),
    .abortEvt(abortEvt), .coreHalted(coreHalted), .coreRestarting(coreRestarting),
    .wpState(wpState), .wpAddr(wpAddr), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .statusOut(statusOut)
  );

  function automatic logic [31:0] wpOffset(input logic [1:0] st);
    return (st == 2'b00) ? 32'd8 : (st == 2'b01) ? 32'd4 : 32'd0;
  endfunction

  function automatic logic [31:0] readExp(input logic [1:0] sel);
    if (sel == 2'd0) return {26'b0, expCause, expRest, expHalt};
    if (sel == 2'd1) return expFault;
    return 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: advance the model from the driven inputs, then compare
  task automatic cyc(input string tag);
    logic [3:0] nCause = expCause;
    logic [31:0] nFault = expFault;
    logic capt = 1'b0;
    if (|ev && !coreHalted) begin
      for (int i = 5; i >= 0; i--) if (ev[i]) nCause = 4'(i);
      if (nCause == 4'd2) begin
        nFault = wpAddr + wpOffset(wpState);
        capt = 1'b1;
      end
    end else if (regWrEn && regSel == 2'd0) begin
      nCause = regWrData[5:2];
    end
    if (!capt && regWrEn && regSel == 2'd1) nFault = regWrData;
    @(posedge clk);
    #2;
    expCause = nCause;
    expFault = nFault;
    expHalt = coreHalted;
    expRest = !coreRestarting;
    check(tag, {26'b0, statusOut}, {26'b0, expCause, expRest, expHalt});
    check(tag, regRdData, readExp(regSel));
    @(negedge clk);
    ev = '0; regWrEn = 1'b0; abortEvt = 1'b0;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #23;
    // R1 reset values
    regSel = 2'd0;
    #1 check("R1 status", regRdData, 32'h2);
    regSel = 2'd1;
    #1 check("R1 fault", regRdData, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    regSel = 2'd0;

    // R2 each single event gives its own code
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ev = 6'(1 << i);
      wpAddr = 32'h1000_0000 + 32'(i * 16);
      regSel = 2'd0;
      cyc("R2");
    end

    // R3 priority among simultaneous events
    ev = 6'b111000; cyc("R3 lowest of 3,4,5");
    ev = 6'b100110; wpAddr = 32'hDEAD_0000; cyc("R3 break over watch");
    ev = 6'b111111; cyc("R3 halt over all");

    // R4 events frozen while halted, R5 halted flag
    coreHalted = 1'b1; cyc("R5 enter halted");
    ev = 6'b000010; cyc("R4 break while halted");
    ev = 6'b000100; regSel = 2'd1; cyc("R4 watch while halted no capture");
    // R9 write while halted takes effect, low bits ignored
    regSel = 2'd0; regWrEn = 1'b1; regWrData = 32'h0000_0017; cyc("R9 write while halted");
    // R6 restarted flag during exit
    coreRestarting = 1'b1; cyc("R6 exiting");
    coreHalted = 1'b0; coreRestarting = 1'b0; cyc("R6 exited");

    // R7 offsets for every state
    regSel = 2'd1;
    for (int s = 0; s < 4; s++) begin
      ev = 6'b000100; wpState = 2'(s); wpAddr = 32'hFFFF_FFF8 + 32'(s); cyc("R7 offset");
    end

    // R8 abort leaves fault and cause alone
    abortEvt = 1'b1; cyc("R8 abort fault");
    regSel = 2'd0; abortEvt = 1'b1; cyc("R8 abort cause");

    // R10 fault write, and capture wins over write
    regSel = 2'd1; regWrEn = 1'b1; regWrData = 32'hCAFE_F00D; cyc("R10 write");
    regWrEn = 1'b1; regWrData = 32'h1111_1111; ev = 6'b000100; wpState = 2'b01;
    wpAddr = 32'h0000_2000; cyc("R10 capture wins");
    // R9 event beats same-cycle status write
    regSel = 2'd0; regWrEn = 1'b1; regWrData = 32'h3C; ev = 6'b010000; cyc("R9 event wins");
    // R11 unused selects read zero
    regSel = 2'd2; cyc("R11 sel2");
    regSel = 2'd3; cyc("R11 sel3");

    // random mix covering R2 R3 R4 R5 R6 R7 R9 R10 R11
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < 6; b++) ev[b] = ($urandom % 4) == 0;
      coreHalted = ($urandom % 3) == 0;
      coreRestarting = ($urandom % 4) == 0;
      abortEvt = ($urandom % 5) == 0;
      wpState = 2'($urandom);
      wpAddr = $urandom;
      regWrEn = ($urandom % 4) == 0;
      regSel = 2'($urandom);
      regWrData = $urandom;
      cyc("R2 R3 R4 R7 R9 R10 R11 random");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule